// File: doc/BRIEF.md
# Pin Direction Arbiter for an 8-bit I/O Port

This block is one slice of a general-purpose I/O port: eight pins with two byte-wide registers on a simple synchronous bus. One register is read-only and returns the pin levels after a two-flop synchronizer. The other register holds one direction bit per pin and can be read and written.

For every pin, the block chooses the output enable and the output level. A pin can be driven by the port's own data, by a PWM channel, or by an SPI function. An enabled peripheral takes the pin away from the direction register. The pin for the highest PWM channel has a shutdown input that forces it to input above every other source. When a pin's peripherals are disabled, its direction bit controls the pin again.

The pin levels are read at offset 0x19. The direction register is at offset 0x1A. Reads return data combinationally from the current address. Writes take effect at the rising clock edge.

Top module: `gpio_override_port`

## Requirements
- R1: After reset, a read at offset 0x1A returns 0x00, and every pin whose peripherals are idle has its output enable low.
- R2: A write at offset 0x1A is stored at the next clock edge, and a later read at 0x1A returns the written byte.
- R3: A read at offset 0x19 returns pin levels delayed by two clock edges. A pin change is not visible after one edge and is visible after the second edge.
- R4: A write at offset 0x19 has no effect: the direction register keeps its value and 0x19 still returns the pin levels.
- R5: A read at any offset other than 0x19 and 0x1A returns 0x00, and a write there leaves the direction register unchanged.
- R6: When a pin has no active peripheral, direction bit value 1 drives the output enable high with the level from the port data input. Direction bit value 0 drives the output enable low.
- R7: When the PWM enable of a pin is set, and neither SPI nor shutdown claims the pin, the output enable is high and the level is that PWM channel's output. The direction bit has no effect on that pin.
- R8: When the SPI enable of a pin is set, and shutdown does not claim the pin, the SPI direction input sets the output enable and the SPI output sets the level. This holds whether or not PWM is enabled on that pin.
- R9: While the shutdown input is high, pin 7 has its output enable low and its output level low, whatever its SPI, PWM and direction settings are. The other pins are not affected.
- R10: When the peripheral enables of a pin are cleared, the direction bit controls that pin again from the same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low asynchronous reset |
| busAddr | input | 8 | Register offset |
| busWr | input | 1 | Write strobe |
| busWdata | input | 8 | Write data |
| busRdata | output | 8 | Read data for busAddr |
| pinIn | input | 8 | Pin levels from the pads |
| gpioOut | input | 8 | Port data to drive on pins in plain I/O mode |
| pwmEn | input | 8 | PWM channel enable, one bit per pin |
| pwmOut | input | 8 | PWM channel output levels |
| spiEn | input | 8 | SPI ownership, one bit per pin |
| spiDir | input | 8 | SPI-chosen direction, 1 means output |
| spiOut | input | 8 | SPI output levels |
| shutEn | input | 1 | Shutdown enable for pin 7, forces input |
| pinOe | output | 8 | Per-pin output enable |
| pinOut | output | 8 | Per-pin output level |

## Verification
The assertions check the arbitration on every cycle. They cover shutdown forcing pin 7 to input, SPI owning the enable and level, PWM forcing output, unmapped offsets reading zero, and the input register matching the pins two edges earlier. Other behaviours need ordered stimulus and only the bench scenarios show them. These are the reset value of the direction register, write-then-read, the ignored writes to the input and unmapped offsets, and a pin returning to its direction bit when its peripherals are released.

// File: rtl/gpio_port_pkg.sv
package gpio_port_pkg;
  typedef struct packed {
    logic dirWrite;
    logic selInput;
    logic selDir;
  } regStrobe_t;
endpackage

// File: rtl/gpio_port_ctrl.sv
module gpio_port_ctrl
  import gpio_port_pkg::*;
#(
  parameter int ADDR_W = 8,
  parameter logic [ADDR_W-1:0] OFF_IN = 8'h19,
  parameter logic [ADDR_W-1:0] OFF_DIR = 8'h1A
) (
  input  logic [ADDR_W-1:0] busAddr,
  input  logic              busWr,
  output regStrobe_t        strobe
);
  logic hitIn, hitDir;

  always_comb begin
    hitIn = (busAddr == OFF_IN);
    hitDir = (busAddr == OFF_DIR);
    strobe.selInput = hitIn;
    strobe.selDir = hitDir;
    // the input register ignores writes; only the direction offset accepts them
    strobe.dirWrite = hitDir && busWr;
  end
endmodule

// File: rtl/gpio_port_dp.sv
module gpio_port_dp
  import gpio_port_pkg::*;
#(
  parameter int WIDTH = 8,
  parameter int SHUT_CH = 7
) (
  input  logic             clk,
  input  logic             rstN,
  input  regStrobe_t       strobe,
  input  logic [WIDTH-1:0] busWdata,
  output logic [WIDTH-1:0] busRdata,
  input  logic [WIDTH-1:0] pinIn,
  input  logic [WIDTH-1:0] gpioOut,
  input  logic [WIDTH-1:0] pwmEn,
  input  logic [WIDTH-1:0] pwmOut,
  input  logic [WIDTH-1:0] spiEn,
  input  logic [WIDTH-1:0] spiDir,
  input  logic [WIDTH-1:0] spiOut,
  input  logic             shutEn,
  output logic [WIDTH-1:0] pinOe,
  output logic [WIDTH-1:0] pinOut
);
  logic [WIDTH-1:0] syncA, syncB;
  logic [WIDTH-1:0] dirReg;

  // pin levels are not reset: they simply follow the pads
  always_ff @(posedge clk) begin
    syncA <= pinIn;
    syncB <= syncA;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) dirReg <= '0;
    else if (strobe.dirWrite) dirReg <= busWdata;
  end

  always_comb begin
    busRdata = '0;
    if (strobe.selInput) busRdata = syncB;
    else if (strobe.selDir) busRdata = dirReg;
  end

  for (genvar i = 0; i < WIDTH; i++) begin : g_pin
    logic shutHit;
    if (i == SHUT_CH) begin : g_shut
      assign shutHit = shutEn;
    end else begin : g_noshut
      assign shutHit = 1'b0;
    end

    // priority: shutdown, SPI, PWM, direction register
    always_comb begin
      if (shutHit) begin
        pinOe[i] = 1'b0;
        pinOut[i] = 1'b0;
      end else if (spiEn[i]) begin
        pinOe[i] = spiDir[i];
        pinOut[i] = spiOut[i];
      end else if (pwmEn[i]) begin
        pinOe[i] = 1'b1;
        pinOut[i] = pwmOut[i];
      end else begin
        pinOe[i] = dirReg[i];
        pinOut[i] = gpioOut[i];
      end
    end
  end
endmodule

// File: rtl/gpio_override_port.sv
module gpio_override_port
  import gpio_port_pkg::*;
#(
  parameter int WIDTH = 8,
  parameter int ADDR_W = 8,
  parameter int SHUT_CH = 7,
  parameter logic [ADDR_W-1:0] OFF_IN = 8'h19,
  parameter logic [ADDR_W-1:0] OFF_DIR = 8'h1A
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic [ADDR_W-1:0] busAddr,
  input  logic              busWr,
  input  logic [WIDTH-1:0]  busWdata,
  output logic [WIDTH-1:0]  busRdata,
  input  logic [WIDTH-1:0]  pinIn,
  input  logic [WIDTH-1:0]  gpioOut,
  input  logic [WIDTH-1:0]  pwmEn,
  input  logic [WIDTH-1:0]  pwmOut,
  input  logic [WIDTH-1:0]  spiEn,
  input  logic [WIDTH-1:0]  spiDir,
  input  logic [WIDTH-1:0]  spiOut,
  input  logic              shutEn,
  output logic [WIDTH-1:0]  pinOe,
  output logic [WIDTH-1:0]  pinOut
);
  regStrobe_t strobe;

  gpio_port_ctrl #(.ADDR_W(ADDR_W), .OFF_IN(OFF_IN), .OFF_DIR(OFF_DIR)) u_ctrl (
    .busAddr(busAddr), .busWr(busWr), .strobe(strobe)
  );

  gpio_port_dp #(.WIDTH(WIDTH), .SHUT_CH(SHUT_CH)) u_dp (
    .clk(clk), .rstN(rstN), .strobe(strobe), .busWdata(busWdata),
    .busRdata(busRdata), .pinIn(pinIn), .gpioOut(gpioOut), .pwmEn(pwmEn),
    .pwmOut(pwmOut), .spiEn(spiEn), .spiDir(spiDir), .spiOut(spiOut),
    .shutEn(shutEn), .pinOe(pinOe), .pinOut(pinOut)
  );
endmodule

// File: rtl/gpio_override_chk.sv
module gpio_override_chk #(
  parameter int WIDTH = 8,
  parameter int ADDR_W = 8,
  parameter int SHUT_CH = 7,
  parameter logic [ADDR_W-1:0] OFF_IN = 8'h19,
  parameter logic [ADDR_W-1:0] OFF_DIR = 8'h1A
) (
  input logic              clk,
  input logic              rstN,
  input logic [ADDR_W-1:0] busAddr,
  input logic [WIDTH-1:0]  busRdata,
  input logic [WIDTH-1:0]  pinIn,
  input logic [WIDTH-1:0]  pwmEn,
  input logic [WIDTH-1:0]  pwmOut,
  input logic [WIDTH-1:0]  spiEn,
  input logic [WIDTH-1:0]  spiDir,
  input logic [WIDTH-1:0]  spiOut,
  input logic              shutEn,
  input logic [WIDTH-1:0]  pinOe,
  input logic [WIDTH-1:0]  pinOut
);
  logic [1:0] edgeCnt;
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) edgeCnt <= '0;
    else if (edgeCnt != 2'd3) edgeCnt <= edgeCnt + 2'd1;
  end

  AST_SHUT_FORCES_INPUT: assert property (@(posedge clk) disable iff (!rstN)
    shutEn |-> (!pinOe[SHUT_CH] && !pinOut[SHUT_CH])); // R9

  AST_UNMAPPED_READ_ZERO: assert property (@(posedge clk) disable iff (!rstN)
    (busAddr != OFF_IN && busAddr != OFF_DIR) |-> (busRdata == '0)); // R5

  AST_INPUT_TWO_EDGES: assert property (@(posedge clk) disable iff (!rstN)
    (edgeCnt >= 2'd2 && busAddr == OFF_IN) |-> (busRdata == $past(pinIn, 2))); // R3

  for (genvar i = 0; i < WIDTH; i++) begin : g_chk
    logic shutHere;
    assign shutHere = (i == SHUT_CH) && shutEn;

    AST_SPI_OWNS_PIN: assert property (@(posedge clk) disable iff (!rstN)
      (spiEn[i] && !shutHere) |-> (pinOe[i] == spiDir[i] && pinOut[i] == spiOut[i])); // R8

    AST_PWM_FORCES_OUTPUT: assert property (@(posedge clk) disable iff (!rstN)
      (pwmEn[i] && !spiEn[i] && !shutHere) |-> (pinOe[i] && pinOut[i] == pwmOut[i])); // R7
  end
endmodule

bind gpio_override_port gpio_override_chk #(
  .WIDTH(WIDTH), .ADDR_W(ADDR_W), .SHUT_CH(SHUT_CH), .OFF_IN(OFF_IN), .OFF_DIR(OFF_DIR)
) u_chk (
  .clk(clk), .rstN(rstN), .busAddr(busAddr), .busRdata(busRdata), .pinIn(pinIn),
  .pwmEn(pwmEn), .pwmOut(pwmOut), .spiEn(spiEn), .spiDir(spiDir), .spiOut(spiOut),
  .shutEn(shutEn), .pinOe(pinOe), .pinOut(pinOut)
);

// File: tb/gpio_override_port_bench.sv
`timescale 1ns/1ps
module gpio_override_port_bench;
  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic [7:0] busAddr = '0;
  logic busWr = 1'b0;
  logic [7:0] busWdata = '0;
  logic [7:0] busRdata;
  logic [7:0] pinIn = '0, gpioOut = '0, pwmEn = '0, pwmOut = '0;
  logic [7:0] spiEn = '0, spiDir = '0, spiOut = '0;
  logic shutEn = 1'b0;
  logic [7:0] pinOe, pinOut;
  int nChecks = 0;
  int nFails = 0;

  localparam logic [7:0] A_IN = 8'h19;
  localparam logic [7:0] A_DIR = 8'h1A;

  always #10 clk = ~clk;

  gpio_override_port u_gpio_override_port (
    .clk(clk), .rstN(rstN), .busAddr(busAddr), .busWr(busWr), .busWdata(busWdata),
    .busRdata(busRdata), .pinIn(pinIn), .gpioOut(gpioOut), .pwmEn(pwmEn),
    .pwmOut(pwmOut), .spiEn(spiEn), .spiDir(spiDir), .spiOut(spiOut),
    .shutEn(shutEn), .pinOe(pinOe), .pinOut(pinOut)
  );

  task automatic check(input string req, input logic [7:0] act, input logic [7:0] exp);
    nChecks++;
    if (act !== exp) begin
      nFails++;
      $display("FAIL %s actual=%02h expected=%02h", req, act, exp);
    end
  endtask

  task automatic writeReg(input logic [7:0] a, input logic [7:0] d);
    @(negedge clk);
    busAddr = a; busWdata = d; busWr = 1'b1;
    @(negedge clk);
    busWr = 1'b0;
  endtask

  task automatic readReg(input logic [7:0] a, output logic [7:0] d);
    @(negedge clk);
    busAddr = a;
    #1 d = busRdata;
  endtask

  task automatic tReset();
    logic [7:0] d;
    readReg(A_DIR, d);
    check("R1 dir reset", d, 8'h00);
    check("R1 oe reset", pinOe, 8'h00);
  endtask

  task automatic tDirRw();
    logic [7:0] d;
    writeReg(A_DIR, 8'h5C);
    readReg(A_DIR, d);
    check("R2 dir readback", d, 8'h5C);
    writeReg(A_DIR, 8'hA3);
    readReg(A_DIR, d);
    check("R2 dir readback 2", d, 8'hA3);
  endtask

  task automatic tInputSync();
    @(negedge clk);
    busAddr = A_IN; pinIn = 8'h00;
    @(negedge clk); @(negedge clk); @(negedge clk);
    pinIn = 8'hA5;
    @(negedge clk);
    #1 check("R3 one edge", busRdata, 8'h00);
    @(negedge clk);
    #1 check("R3 two edges", busRdata, 8'hA5);
  endtask

  task automatic tInputWrite();
    logic [7:0] d;
    writeReg(A_DIR, 8'h3C);
    writeReg(A_IN, 8'hFF);
    readReg(A_DIR, d);
    check("R4 dir kept", d, 8'h3C);
    readReg(A_IN, d);
    check("R4 input still pins", d, 8'hA5);
  endtask

  task automatic tUnmapped();
    logic [7:0] d;
    readReg(8'h18, d);
    check("R5 unmapped read 18", d, 8'h00);
    readReg(8'h1B, d);
    check("R5 unmapped read 1B", d, 8'h00);
    writeReg(8'h1B, 8'hFF);
    writeReg(8'h00, 8'h00);
    readReg(A_DIR, d);
    check("R5 dir kept after unmapped writes", d, 8'h3C);
  endtask

  task automatic tGpio();
    writeReg(A_DIR, 8'h0F);
    gpioOut = 8'h96;
    #1;
    check("R6 oe from dir", pinOe, 8'h0F);
    check("R6 out from port data", pinOut, 8'h96);
  endtask

  task automatic tPwm();
    @(negedge clk);
    pwmEn = 8'hF0; pwmOut = 8'h50;
    #1;
    check("R7 pwm oe", pinOe, 8'hFF);
    check("R7 pwm out", pinOut, 8'h56);
  endtask

  task automatic tSpi();
    @(negedge clk);
    spiEn = 8'h3C; spiDir = 8'h28; spiOut = 8'h24;
    #1;
    check("R8 spi oe", pinOe, 8'hEB);
    check("R8 spi out", pinOut, 8'h66);
  endtask

  task automatic tShutdown();
    @(negedge clk);
    spiEn = 8'hBC; spiDir = 8'hA8; spiOut = 8'hA4;
    pwmOut = 8'hD0;
    shutEn = 1'b1;
    #1;
    check("R9 shutdown oe", pinOe, 8'h6B);
    check("R9 shutdown out", pinOut, 8'h66);
    shutEn = 1'b0;
    #1;
    check("R9 released to spi", pinOe, 8'hEB);
  endtask

  task automatic tRelease();
    @(negedge clk);
    pwmEn = '0; spiEn = '0;
    #1;
    check("R10 oe back to dir", pinOe, 8'h0F);
    check("R10 out back to port data", pinOut, 8'h96);
  endtask

  initial begin
    #(20 * 200000);
    nChecks++; nFails++;
    $display("FAIL watchdog actual=%02h expected=%02h", 8'h00, 8'h01);
    $display("%0d/%0d checks passed", nChecks - nFails, nChecks);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    tReset();
    tDirRw();
    tInputSync();
    tInputWrite();
    tUnmapped();
    tGpio();
    tPwm();
    tSpi();
    tShutdown();
    tRelease();
    $display("%0d/%0d checks passed", nChecks - nFails, nChecks);
    $finish;
  end
endmodule